// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Converter

This block takes a packed IEEE-754 double-precision operand and produces a 32-bit integer, signed or unsigned. A select input picks the integer type. A two-bit mode input picks the rounding direction. A truncate input overrides that mode and forces rounding toward zero. Next to the integer, the block reports three flags:
- invalid, for saturation and for negative results in unsigned mode;
- inexact, when discarded fraction bits were nonzero;
- input-denormal, when the operand was subnormal.

The operand is split into sign, exponent and significand. The significand is right-shifted so its binary point sits at the integer position. The bits shifted out form a 64-bit remainder. A mode-dependent increment is added to that remainder, and the carry out rounds the integer. Operands too large for the target type, infinities and NaNs get fixed saturated values. Magnitudes below one half take a separate path: they give 0, or ±1 under the directed modes.

The result is registered. Each operand presented with `valid_i` gives one result, with `valid_o` high, on the following cycle.

Top module: `dbl2int_cvt`

## Requirements
- R1: With `valid_i` high at a clock edge, `result_o` and the flags are registered at that edge and `valid_o` is high for that one cycle. `valid_o` is 0 in every cycle after an edge with `valid_i` low. Reset clears `valid_o`, `result_o` and all flags.
- R2: `rmode_i` encodes 0 as nearest-even, 1 as toward +infinity, 2 as toward -infinity and 3 as toward zero. When `trunc_i` is 1, the value of `rmode_i` has no effect and rounding is toward zero.
- R3: For unbiased exponents from -1 to 31, the result is the integer part, rounded by the discarded bits under the chosen mode. `inexact_o` rises when any discarded bit is nonzero, unless the result was saturated.
- R4: Under nearest-even, an exact half rounds to the even integer: 2.5 gives 2, 3.5 gives 4, 0.5 gives 0.
- R5: In signed mode, a NaN gives 0 with `invalid_o`.
- R6: In signed mode, a finite operand with unbiased exponent of 32 or more, an infinity, or a rounded magnitude above 0x7FFFFFFF (positive) or 0x80000000 (negative) gives 0x7FFFFFFF or 0x80000000 by sign, with `invalid_o` and without `inexact_o`. The value -2^31 converts exactly.
- R7: In unsigned mode, an operand with unbiased exponent of 32 or more, including infinities and NaNs, gives 0 when the sign bit is set and 0xFFFFFFFF otherwise, with `invalid_o`.
- R8: In unsigned mode, a negative operand whose rounded magnitude is nonzero gives 0 with `invalid_o` and without `inexact_o`. A negative operand that rounds to magnitude 0 gives 0 with only `inexact_o`.
- R9: A nonzero magnitude below one half always sets `inexact_o` and otherwise gives 0, except in three cases:
  - +1 for positive operands toward +infinity;
  - 0xFFFFFFFF (-1) for negative operands toward -infinity in signed mode;
  - 0 with `invalid_o` for negative operands toward -infinity in unsigned mode.
  
  A zero of either sign gives 0 with no flags.
- R10: `denorm_o` is 1 exactly when the exponent field is zero and the fraction is nonzero.
- R11: In unsigned mode, when the integer part is 0xFFFFFFFF and rounding would carry beyond it, the result stays 0xFFFFFFFF and `invalid_o` is raised, together with `inexact_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and controls are valid this cycle |
| operand_i | input | 64 | Packed double-precision operand |
| is_signed_i | input | 1 | 1 selects a signed result, 0 unsigned |
| rmode_i | input | 2 | Rounding mode (0 nearest-even, 1 +inf, 2 -inf, 3 zero) |
| trunc_i | input | 1 | Force rounding toward zero |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 32 | Converted integer |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |
| denorm_o | output | 1 | Subnormal-input flag |

## Verification
The bench targets the edges where a converter goes wrong quietly.
- Ties at 0.5, 2.5 and 3.5: a design that rounds half away from zero returns 1, 3 and 4 instead of 0, 2 and 4.
- Values 2^31, -2^31, 2^31-0.5, 2^32 and 2^32-0.5: an off-by-one limit lets 2^31 through as a negative number, or wraps 2^32-0.5 to 0 in unsigned mode.
- Quarter and half magnitudes under each directed mode, signed and unsigned: these expose a missing ±1 or a missing invalid flag.
- NaNs in both modes, with every rounding mode and with truncation forced: these catch a NaN treated as a large number in signed mode, and a truncate input that does not take priority.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_POS  = 2'd1,
    RM_NEG  = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    RG_SMALL = 2'd0,  // magnitude below one half
    RG_MID   = 2'd1,  // shift-and-round path
    RG_BIG   = 2'd2   // saturate path
  } region_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
    logic denorm;
  } flags_t;
endpackage

// File: rtl/dcv_classify.sv
module dcv_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int WORK_W = 64,
  localparam int DBL_W = 1 + EXP_W + FRAC_W,
  localparam int PAD_W = WORK_W - 1 - FRAC_W
) (
  input  logic [DBL_W-1:0]  operand_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [WORK_W-1:0] sig_o,
  output logic              is_nan_o,
  output logic              is_zero_o,
  output logic              is_denorm_o
);
  logic [FRAC_W-1:0] frac;
  logic              exp_zero, exp_ones, frac_nz;

  assign sign_o   = operand_i[DBL_W-1];
  assign exp_o    = operand_i[FRAC_W +: EXP_W];
  assign frac     = operand_i[FRAC_W-1:0];
  assign exp_zero = (exp_o == '0);
  assign exp_ones = &exp_o;
  assign frac_nz  = |frac;

  // hidden bit lands on the top bit of the working significand
  assign sig_o       = {~exp_zero, frac, {PAD_W{1'b0}}};
  assign is_nan_o    = exp_ones & frac_nz;
  assign is_zero_o   = exp_zero & ~frac_nz;
  assign is_denorm_o = exp_zero & frac_nz;
endmodule

// File: rtl/dcv_align.sv
module dcv_align
  import dcv_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int WORK_W = 64,
  parameter int INT_W  = 32,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int SH_W  = EXP_W + 1
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [WORK_W-1:0] sig_i,
  output region_e           region_o,
  output logic [INT_W-1:0]  int_o,
  output logic [WORK_W-1:0] rem_o
);
  localparam logic [EXP_W-1:0] EXP_BIG = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] EXP_MID = EXP_W'(BIAS - 1);
  localparam logic [SH_W-1:0]  SH_BASE = SH_W'(BIAS + WORK_W - 1);

  logic [SH_W-1:0] rsh, lsh;

  assign rsh = SH_BASE - {1'b0, exp_i};
  assign lsh = SH_W'(WORK_W) - rsh;

  always_comb begin
    if (exp_i >= EXP_BIG)      region_o = RG_BIG;
    else if (exp_i >= EXP_MID) region_o = RG_MID;
    else                       region_o = RG_SMALL;
  end

  // rsh lies in [WORK_W-INT_W, WORK_W] on the mid path
  assign int_o = INT_W'(sig_i >> rsh);
  assign rem_o = sig_i << lsh;
endmodule

// File: rtl/dcv_round.sv
module dcv_round
  import dcv_pkg::*;
#(
  parameter int WORK_W = 64,
  parameter int INT_W  = 32
) (
  input  region_e           region_i,
  input  rmode_e            rmode_i,
  input  logic              sign_i,
  input  logic              is_signed_i,
  input  logic              is_nan_i,
  input  logic              is_zero_i,
  input  logic              is_denorm_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [WORK_W-1:0] rem_i,
  output logic [INT_W-1:0]  result_o,
  output flags_t            flags_o
);
  localparam logic [WORK_W-1:0] HALF = {1'b1, {(WORK_W-1){1'b0}}};
  localparam logic [INT_W-1:0]  UMAX = '1;
  localparam logic [INT_W-1:0]  SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0]  SMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0]  ONE  = INT_W'(1);

  logic [WORK_W-1:0] incr;
  logic [WORK_W:0]   rsum;
  logic              carry, sat_u, s_over, rem_nz;
  logic [INT_W-1:0]  mag;

  always_comb begin
    unique case (rmode_i)
      RM_NEAR: incr = int_i[0] ? HALF : HALF - 1'b1;
      RM_POS:  incr = sign_i ? '0 : '1;
      RM_NEG:  incr = sign_i ? '1 : '0;
      default: incr = '0;
    endcase
  end

  assign rsum   = {1'b0, rem_i} + {1'b0, incr};
  assign carry  = rsum[WORK_W];
  assign sat_u  = carry & (int_i == UMAX);
  assign mag    = int_i + INT_W'(carry & ~sat_u);
  assign rem_nz = |rem_i;
  assign s_over = mag[INT_W-1] & (~sign_i | (|mag[INT_W-2:0]));

  always_comb begin
    result_o        = '0;
    flags_o         = '0;
    flags_o.denorm  = is_denorm_i;
    unique case (region_i)
      RG_BIG: begin
        flags_o.invalid = 1'b1;
        if (is_signed_i) result_o = is_nan_i ? '0 : (sign_i ? SMIN : SMAX);
        else             result_o = sign_i ? '0 : UMAX;
      end
      RG_MID: begin
        if (is_signed_i) begin
          if (s_over) begin
            result_o        = sign_i ? SMIN : SMAX;
            flags_o.invalid = 1'b1;
          end else begin
            result_o        = sign_i ? -mag : mag;
            flags_o.inexact = rem_nz;
          end
        end else begin
          flags_o.invalid = sat_u;
          if (sign_i && mag != '0) begin
            flags_o.invalid = 1'b1;
          end else begin
            result_o        = sign_i ? '0 : mag;
            flags_o.inexact = rem_nz;
          end
        end
      end
      default: begin
        if (!is_zero_i) begin
          flags_o.inexact = 1'b1;
          if (rmode_i == RM_POS && !sign_i) begin
            result_o = ONE;
          end else if (rmode_i == RM_NEG && sign_i) begin
            if (is_signed_i) result_o = UMAX;
            else             flags_o.invalid = 1'b1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import dcv_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  parameter int WORK_W = 64,
  localparam int DBL_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DBL_W-1:0] operand_i,
  input  logic             is_signed_i,
  input  logic [1:0]       rmode_i,
  input  logic             trunc_i,
  output logic             valid_o,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o,
  output logic             denorm_o
);
  logic              sign, is_nan, is_zero, is_denorm;
  logic [EXP_W-1:0]  exp_f;
  logic [WORK_W-1:0] sig, rem;
  logic [INT_W-1:0]  int_part, res_d;
  region_e           region;
  rmode_e            rmode_eff;
  flags_t            flags_d;

  assign rmode_eff = trunc_i ? RM_ZERO : rmode_e'(rmode_i);

  dcv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .WORK_W(WORK_W)) i_classify (
    .operand_i  (operand_i),
    .sign_o     (sign),
    .exp_o      (exp_f),
    .sig_o      (sig),
    .is_nan_o   (is_nan),
    .is_zero_o  (is_zero),
    .is_denorm_o(is_denorm)
  );

  dcv_align #(.EXP_W(EXP_W), .WORK_W(WORK_W), .INT_W(INT_W)) i_align (
    .exp_i   (exp_f),
    .sig_i   (sig),
    .region_o(region),
    .int_o   (int_part),
    .rem_o   (rem)
  );

  dcv_round #(.WORK_W(WORK_W), .INT_W(INT_W)) i_round (
    .region_i   (region),
    .rmode_i    (rmode_eff),
    .sign_i     (sign),
    .is_signed_i(is_signed_i),
    .is_nan_i   (is_nan),
    .is_zero_i  (is_zero),
    .is_denorm_i(is_denorm),
    .int_i      (int_part),
    .rem_i      (rem),
    .result_o   (res_d),
    .flags_o    (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        invalid_o <= flags_d.invalid;
        inexact_o <= flags_d.inexact;
        denorm_o  <= flags_d.denorm;
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R5
  signed_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(is_signed_i && (&operand_i[FRAC_W +: EXP_W]) && (|operand_i[FRAC_W-1:0]))
    |-> (result_o == '0) && invalid_o);

  // R8
  unsigned_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(!is_signed_i && operand_i[DBL_W-1]) |-> result_o == '0);

  // R10
  denorm_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> denorm_o == $past((operand_i[FRAC_W +: EXP_W] == '0) && (|operand_i[FRAC_W-1:0])));

  // R6, R7
  big_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(operand_i[FRAC_W +: EXP_W] >= EXP_W'(BIAS + INT_W)) |-> invalid_o);
endmodule

// File: tb/test_dbl2int_cvt.sv
`timescale 1ns/1ps
module test_dbl2int_cvt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        is_signed_i = 1'b0;
  logic [1:0]  rmode_i = 2'd0;
  logic        trunc_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        invalid_o, inexact_o, denorm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [2:0] F_N = 3'b000, F_I = 3'b100, F_X = 3'b010, F_D = 3'b001;
  localparam logic [1:0] NE = 2'd0, UP = 2'd1, DN = 2'd2, TZ = 2'd3;

  localparam logic [63:0] D_1P0   = 64'h3FF0000000000000;
  localparam logic [63:0] D_2P5   = 64'h4004000000000000;
  localparam logic [63:0] D_3P5   = 64'h400C000000000000;
  localparam logic [63:0] D_M1P5  = 64'hBFF8000000000000;
  localparam logic [63:0] D_HALF  = 64'h3FE0000000000000;
  localparam logic [63:0] D_MHALF = 64'hBFE0000000000000;
  localparam logic [63:0] D_QTR   = 64'h3FD0000000000000;
  localparam logic [63:0] D_MQTR  = 64'hBFD0000000000000;
  localparam logic [63:0] D_P31   = 64'h41E0000000000000;
  localparam logic [63:0] D_MP31  = 64'hC1E0000000000000;
  localparam logic [63:0] D_P32   = 64'h41F0000000000000;
  localparam logic [63:0] D_MP32  = 64'hC1F0000000000000;
  localparam logic [63:0] D_P31H  = 64'h41DFFFFFFFE00000;  // 2^31 - 0.5
  localparam logic [63:0] D_P32H  = 64'h41EFFFFFFFF00000;  // 2^32 - 0.5
  localparam logic [63:0] D_QNAN  = 64'h7FF8000000000000;
  localparam logic [63:0] D_MNAN  = 64'hFFF8000000000000;
  localparam logic [63:0] D_SNAN  = 64'h7FF0000000000001;
  localparam logic [63:0] D_INF   = 64'h7FF0000000000000;
  localparam logic [63:0] D_MINF  = 64'hFFF0000000000000;
  localparam logic [63:0] D_DEN   = 64'h0000000000000001;
  localparam logic [63:0] D_MZERO = 64'h8000000000000000;

  dbl2int_cvt i_dbl2int_cvt (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .operand_i(operand_i),
    .is_signed_i(is_signed_i), .rmode_i(rmode_i), .trunc_i(trunc_i),
    .valid_o(valid_o), .result_o(result_o), .invalid_o(invalid_o),
    .inexact_o(inexact_o), .denorm_o(denorm_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] got_r,
                       input logic [2:0] got_f, input logic [31:0] exp_r, input logic [2:0] exp_f);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got result=%h flags(i,x,d)=%b, expected result=%h flags=%b",
               tag, got_r, got_f, exp_r, exp_f);
    end
  endtask

  task automatic conv(input logic [63:0] op, input logic sg, input logic [1:0] rm, input logic tr,
                      input logic [31:0] er, input logic [2:0] ef, input string tag);
    logic [2:0] gf;
    @(negedge clk_i);
    operand_i = op; is_signed_i = sg; rmode_i = rm; trunc_i = tr; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    gf = {invalid_o, inexact_o, denorm_o};
    check(valid_o === 1'b1 && result_o === er && gf === ef, tag, result_o, gf, er, ef);
  endtask

  task automatic t_reset();
    check(valid_o === 1'b0 && result_o === '0 && {invalid_o, inexact_o, denorm_o} === F_N,
          "R1 reset state", result_o, {invalid_o, inexact_o, denorm_o}, '0, F_N);
  endtask

  task automatic t_latency();
    conv(D_3P5, 1'b1, NE, 1'b0, 32'd4, F_X, "R1 capture");
    @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === 32'd4, "R1 valid drops, result held",
          result_o, {invalid_o, inexact_o, denorm_o}, 32'd4, F_X);
  endtask

  task automatic t_basic();
    conv(D_1P0,  1'b1, NE, 1'b0, 32'd1,        F_N, "R3 one exact");
    conv(D_M1P5, 1'b1, TZ, 1'b0, 32'hFFFFFFFF, F_X, "R3 -1.5 toward zero");
    conv(D_M1P5, 1'b1, NE, 1'b0, 32'hFFFFFFFE, F_X, "R3 -1.5 nearest");
    conv(D_3P5,  1'b0, NE, 1'b0, 32'd4,        F_X, "R3 unsigned 3.5");
    conv(64'h0,  1'b1, NE, 1'b0, 32'd0,        F_N, "R9 zero no flags");
    conv(D_MZERO,1'b1, DN, 1'b0, 32'd0,        F_N, "R9 minus zero no flags");
  endtask

  task automatic t_ties();
    conv(D_2P5,  1'b1, NE, 1'b0, 32'd2, F_X, "R4 2.5 to even");
    conv(D_3P5,  1'b1, NE, 1'b0, 32'd4, F_X, "R4 3.5 to even");
    conv(D_HALF, 1'b1, NE, 1'b0, 32'd0, F_X, "R4 0.5 to even");
    conv(D_MHALF,1'b1, NE, 1'b0, 32'd0, F_X, "R4 -0.5 to even");
  endtask

  task automatic t_modes();
    conv(D_2P5,  1'b1, UP, 1'b0, 32'd3,        F_X, "R2 2.5 up");
    conv(D_2P5,  1'b1, DN, 1'b0, 32'd2,        F_X, "R2 2.5 down");
    conv(D_2P5,  1'b1, TZ, 1'b0, 32'd2,        F_X, "R2 2.5 zero");
    conv(D_M1P5, 1'b1, DN, 1'b0, 32'hFFFFFFFE, F_X, "R2 -1.5 down");
    conv(D_M1P5, 1'b1, UP, 1'b0, 32'hFFFFFFFF, F_X, "R2 -1.5 up");
    conv(D_HALF, 1'b1, UP, 1'b0, 32'd1,        F_X, "R2 0.5 up");
    conv(D_HALF, 1'b1, DN, 1'b0, 32'd0,        F_X, "R2 0.5 down");
    conv(D_MHALF,1'b1, DN, 1'b0, 32'hFFFFFFFF, F_X, "R2 -0.5 down");
    conv(D_MHALF,1'b1, UP, 1'b0, 32'd0,        F_X, "R2 -0.5 up");
  endtask

  task automatic t_trunc();
    conv(D_2P5,  1'b1, UP, 1'b1, 32'd2,        F_X, "R2 trunc overrides up");
    conv(D_M1P5, 1'b1, DN, 1'b1, 32'hFFFFFFFF, F_X, "R2 trunc overrides down");
    conv(D_QTR,  1'b1, UP, 1'b1, 32'd0,        F_X, "R2 trunc small");
    conv(D_P31H, 1'b1, NE, 1'b1, 32'h7FFFFFFF, F_X, "R2 trunc below 2^31");
  endtask

  task automatic t_small();
    conv(D_QTR,  1'b1, UP, 1'b0, 32'd1,        F_X,       "R9 0.25 up");
    conv(D_QTR,  1'b1, NE, 1'b0, 32'd0,        F_X,       "R9 0.25 nearest");
    conv(D_MQTR, 1'b1, DN, 1'b0, 32'hFFFFFFFF, F_X,       "R9 -0.25 down signed");
    conv(D_MQTR, 1'b1, UP, 1'b0, 32'd0,        F_X,       "R9 -0.25 up signed");
    conv(D_MQTR, 1'b0, DN, 1'b0, 32'd0,        F_I | F_X, "R9 -0.25 down unsigned");
    conv(D_QTR,  1'b0, UP, 1'b0, 32'd1,        F_X,       "R9 0.25 up unsigned");
  endtask

  task automatic t_signed_bounds();
    conv(D_P31,  1'b1, NE, 1'b0, 32'h7FFFFFFF, F_I, "R6 2^31 clamps");
    conv(D_MP31, 1'b1, NE, 1'b0, 32'h80000000, F_N, "R6 -2^31 exact");
    conv(D_P31H, 1'b1, NE, 1'b0, 32'h7FFFFFFF, F_I, "R6 2^31-0.5 rounds over");
    conv(D_P32,  1'b1, TZ, 1'b0, 32'h7FFFFFFF, F_I, "R6 2^32 signed");
    conv(D_MP32, 1'b1, TZ, 1'b0, 32'h80000000, F_I, "R6 -2^32 signed");
    conv(D_INF,  1'b1, NE, 1'b0, 32'h7FFFFFFF, F_I, "R6 +inf signed");
    conv(D_MINF, 1'b1, NE, 1'b0, 32'h80000000, F_I, "R6 -inf signed");
  endtask

  task automatic t_unsigned_bounds();
    conv(D_P31,  1'b0, NE, 1'b0, 32'h80000000, F_N,       "R7 2^31 unsigned fits");
    conv(D_P32,  1'b0, NE, 1'b0, 32'hFFFFFFFF, F_I,       "R7 2^32 unsigned");
    conv(D_MP32, 1'b0, NE, 1'b0, 32'd0,        F_I,       "R7 -2^32 unsigned");
    conv(D_INF,  1'b0, UP, 1'b0, 32'hFFFFFFFF, F_I,       "R7 +inf unsigned");
    conv(D_P32H, 1'b0, NE, 1'b0, 32'hFFFFFFFF, F_I | F_X, "R11 carry past max");
    conv(D_P32H, 1'b0, TZ, 1'b0, 32'hFFFFFFFF, F_X,       "R11 no carry toward zero");
  endtask

  task automatic t_nan();
    for (int m = 0; m < 4; m++) begin
      conv(D_QNAN, 1'b1, 2'(m), 1'b0, 32'd0,        F_I, $sformatf("R5 qnan signed mode %0d", m));
      conv(D_QNAN, 1'b0, 2'(m), 1'b0, 32'hFFFFFFFF, F_I, $sformatf("R7 qnan unsigned mode %0d", m));
    end
    conv(D_SNAN, 1'b1, NE, 1'b1, 32'd0, F_I, "R5 snan signed trunc");
    conv(D_MNAN, 1'b1, UP, 1'b0, 32'd0, F_I, "R5 negative nan signed");
    conv(D_MNAN, 1'b0, UP, 1'b0, 32'd0, F_I, "R7 negative nan unsigned");
  endtask

  task automatic t_unsigned_neg();
    conv(D_M1P5, 1'b0, NE, 1'b0, 32'd0, F_I, "R8 -1.5 unsigned");
    conv(D_MHALF,1'b0, NE, 1'b0, 32'd0, F_X, "R8 -0.5 rounds to zero");
    conv(D_MHALF,1'b0, DN, 1'b0, 32'd0, F_I, "R8 -0.5 down unsigned");
    conv(D_MHALF,1'b0, UP, 1'b0, 32'd0, F_X, "R8 -0.5 up unsigned");
  endtask

  task automatic t_denorm();
    conv(D_DEN, 1'b1, UP, 1'b0, 32'd1, F_X | F_D, "R10 denormal up");
    conv(D_DEN, 1'b1, NE, 1'b0, 32'd0, F_X | F_D, "R10 denormal nearest");
    conv(D_QTR, 1'b1, NE, 1'b0, 32'd0, F_X,       "R10 normal no flag");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latency();
    t_basic();
    t_ties();
    t_modes();
    t_trunc();
    t_small();
    t_signed_bounds();
    t_unsigned_bounds();
    t_nan();
    t_unsigned_neg();
    t_denorm();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule